// File: doc/BRIEF.md
# Coherent AGC Loop Controller

This block closes a digital automatic gain control loop in a baseband receiver. Each strobed sample arrives from one of two signed sample sources. The block removes the slowly varying DC level from the sample and measures its magnitude against a target level. The difference between the two is integrated into a 16-bit gain word. A fast PWM output carries the gain word. Separate gain-up and gain-down pulses tell an external tuner and demodulator when the word leaves its working window.

A small write-only register port sets the loop up. Register 0 can freeze the whole loop. It also chooses which target level the loop uses: a fixed built-in level, or the 8-bit value held in register 1. A change of target applies from the next strobed sample. The loop produces nothing until valid samples arrive.

Top module: `agc_loop_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `gain_level` is 16'h8000, both gain pulses are low, the DC estimate is zero, the PWM counter is zero, and register 0 and register 1 are cleared.
- R2: The sample used is `samp_a` when `in_sel` is 0 and `samp_b` when `in_sel` is 1.
- R3: DC reduction keeps an accumulator M (reset 0) and the estimate E = floor(M / 256). Each accepted sample x gives D = x - E, and M then becomes M + D.
- R4: On each clock edge with `in_valid` high and the loop not held, `gain_level` becomes clamp(`gain_level` + |D| - ref, 0, 65535). The new value shows after that edge. Without `in_valid`, `gain_level` does not change.
- R5: When register 0 bit 1 is 0, ref is the built-in level 64 (8'h40), whatever register 1 holds.
- R6: A write happens on a clock edge with `cfg_wr` high. Address 0 stores bit 0 as hold and bit 1 as reference select. Address 1 stores the 8-bit reference. With select at 1, ref is register 1, starting with the first valid sample after the write.
- R7: While hold is 1, the loop ignores samples. `gain_level`, the DC estimate and the PWM counter keep their values, and no gain pulse is issued.
- R8: `gain_level` saturates at 65535 and at 0 and does not wrap.
- R9: `gain_dn` is high for exactly one cycle after an update that takes `gain_level` from at most 16'hE000 to above it. `gain_up` is high for exactly one cycle after an update that takes it from at least 16'h2000 to below it. The two are never high together.
- R10: An 8-bit counter advances every unheld cycle. `pwm_out` is high while the counter is below `gain_level[15:8]`, so over any 256 consecutive unheld cycles with no update it is high for `gain_level[15:8]` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_sel | input | 1 | Sample source select (0: samp_a, 1: samp_b) |
| samp_a | input | 10 | Signed sample, source A |
| samp_b | input | 10 | Signed sample, source B |
| in_valid | input | 1 | Sample strobe |
| cfg_wr | input | 1 | Register write enable |
| cfg_addr | input | 1 | Register address |
| cfg_wdata | input | 8 | Register write data |
| gain_level | output | 16 | Loop accumulator (gain word) |
| pwm_out | output | 1 | PWM gain-control output |
| gain_up | output | 1 | One-cycle gain-up pulse |
| gain_dn | output | 1 | One-cycle gain-down pulse |

## Verification
The loop is driven with several kinds of input. A constant offset shows whether the DC estimate is actually subtracted, because without it the error would stay fixed. Different values on the two sources separate the input select. Alternating large swings drive the word into upper saturation and across the gain-down threshold. A run of zero samples drains it through the gain-up threshold into lower saturation. Reference writes made with the select bit at each value show apart the default level, the host level and the moment the switch takes effect. PWM duty is counted at reset, at full scale and at zero.

// File: rtl/agc_pkg.sv
// Package: types shared by the AGC loop blocks.
// Assumes an 8-bit reference and a two-entry register space.
package agc_pkg;
    localparam int REF_W = 8;

    // Loop configuration held in the register file
    typedef struct packed {
        logic             hold;     // freeze the loop
        logic             ref_sel;  // 1: host reference, 0: built-in
        logic [REF_W-1:0] ref_val;  // host-written reference
    } agc_cfg_t;
endpackage

// File: rtl/agc_regs.sv
// Register file for the AGC loop.
// Address 0: bit0 hold, bit1 reference select. Address 1: reference value.
// Assumes single-cycle writes and no read path. It also picks the active reference.
module agc_regs
    import agc_pkg::*;
#(
    parameter logic [REF_W-1:0] DEFAULT_REF = 8'h40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             addr,
    input  logic [REF_W-1:0] wdata,
    output agc_cfg_t         cfg_o,
    output logic [REF_W-1:0] ref_o
);
    agc_cfg_t cfg_q;

    // Store register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr) begin
            if (addr == 1'b0) begin
                cfg_q.hold    <= wdata[0];
                cfg_q.ref_sel <= wdata[1];
            end else begin
                cfg_q.ref_val <= wdata;
            end
        end
    end

    // Choose the reference in effect
    always_comb ref_o = cfg_q.ref_sel ? cfg_q.ref_val : DEFAULT_REF;

    assign cfg_o = cfg_q;
endmodule

// File: rtl/agc_dc_reduce.sv
// DC reduction: a leaky integrator tracks the running mean, and the mean is
// subtracted from the sample. The integrator moves only when adv is high.
// Assumes DC_SHIFT >= 1.
module agc_dc_reduce #(
    parameter int SAMPLE_W = 10,
    parameter int DC_SHIFT = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adv,
    input  logic signed [SAMPLE_W-1:0] x_i,
    output logic signed [SAMPLE_W:0]   dcr_o
);
    localparam int M_W = SAMPLE_W + DC_SHIFT;
    localparam int D_W = SAMPLE_W + 1;

    logic signed [M_W-1:0]      macc_q;
    logic signed [M_W-1:0]      mshift;
    logic signed [SAMPLE_W-1:0] mean;

    // Integer part of the mean estimate
    always_comb begin
        mshift = macc_q >>> DC_SHIFT;
        mean   = mshift[SAMPLE_W-1:0];
    end

    // Sample minus the mean, one bit wider
    always_comb dcr_o = $signed({x_i[SAMPLE_W-1], x_i}) - $signed({mean[SAMPLE_W-1], mean});

    // Add the residual into the integrator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            macc_q <= '0;
        end else if (adv) begin
            macc_q <= macc_q + $signed({{(M_W-D_W){dcr_o[D_W-1]}}, dcr_o});
        end
    end
endmodule

// File: rtl/agc_err_acc.sv
// Error and accumulator: adds |dcr| - ref to a saturating gain word on each
// accepted sample. Issues one-cycle pulses when the word crosses a threshold.
// Assumes LO_THR < HI_THR, so the two pulses can never coincide.
module agc_err_acc #(
    parameter int             SAMPLE_W = 10,
    parameter int             ACC_W    = 16,
    parameter int             REF_W    = 8,
    parameter logic [ACC_W-1:0] LO_THR = 16'h2000,
    parameter logic [ACC_W-1:0] HI_THR = 16'hE000,
    parameter logic [ACC_W-1:0] ACC_RST = 16'h8000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv,
    input  logic                     hold,
    input  logic signed [SAMPLE_W:0] dcr_i,
    input  logic [REF_W-1:0]         ref_i,
    output logic [ACC_W-1:0]         acc_o,
    output logic                     up_o,
    output logic                     dn_o
);
    localparam int D_W   = SAMPLE_W + 1;
    localparam int ERR_W = ((D_W > REF_W) ? D_W : REF_W) + 1;
    localparam int SUM_W = ((ACC_W > ERR_W) ? ACC_W : ERR_W) + 2;

    logic [ACC_W-1:0] acc_q, acc_nxt;
    logic [D_W-1:0]   mag;
    logic [ERR_W-1:0] err;
    logic [SUM_W-1:0] sum;
    logic             neg, over;

    // Magnitude of the DC-free sample minus the reference
    always_comb begin
        mag = dcr_i[D_W-1] ? D_W'(-dcr_i) : D_W'(dcr_i);
        err = ERR_W'(mag) - ERR_W'(ref_i);
    end

    // Widened sum, then clamp into the accumulator range
    always_comb begin
        sum     = SUM_W'(acc_q) + {{(SUM_W-ERR_W){err[ERR_W-1]}}, err};
        neg     = sum[SUM_W-1];
        over    = !neg && (|sum[SUM_W-2:ACC_W]);
        acc_nxt = neg ? '0 : (over ? '1 : sum[ACC_W-1:0]);
    end

    // Update the gain word and detect threshold crossings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= ACC_RST;
            up_o  <= 1'b0;
            dn_o  <= 1'b0;
        end else if (hold) begin
            up_o  <= 1'b0;
            dn_o  <= 1'b0;
        end else begin
            up_o  <= adv && (acc_nxt < LO_THR) && (acc_q >= LO_THR);
            dn_o  <= adv && (acc_nxt > HI_THR) && (acc_q <= HI_THR);
            if (adv) acc_q <= acc_nxt;
        end
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/agc_pwm.sv
// PWM generator: a free-running counter is compared with the duty value.
// The counter stops while run is low, which freezes the output level.
module agc_pwm #(
    parameter int PWM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PWM_W-1:0] duty,
    output logic             pwm_o
);
    logic [PWM_W-1:0] cnt_q;

    // Advance the PWM period counter
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + 1'b1;
    end

    // High while the counter is below the duty value
    always_comb pwm_o = (cnt_q < duty);
endmodule

// File: rtl/agc_loop_ctrl.sv
// Top level of the coherent AGC loop. Selects an input, removes DC, integrates
// the error against the reference, and drives the PWM and gain pulses.
// Assumes samples are two's complement and in_valid marks one sample per cycle.
module agc_loop_ctrl
    import agc_pkg::*;
#(
    parameter int               SAMPLE_W    = 10,
    parameter int               DC_SHIFT    = 8,
    parameter int               ACC_W       = 16,
    parameter int               PWM_W       = 8,
    parameter logic [REF_W-1:0] DEFAULT_REF = 8'h40,
    parameter logic [ACC_W-1:0] LO_THR      = 16'h2000,
    parameter logic [ACC_W-1:0] HI_THR      = 16'hE000,
    parameter logic [ACC_W-1:0] ACC_RST     = 16'h8000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_sel,
    input  logic signed [SAMPLE_W-1:0] samp_a,
    input  logic signed [SAMPLE_W-1:0] samp_b,
    input  logic                       in_valid,
    input  logic                       cfg_wr,
    input  logic                       cfg_addr,
    input  logic [REF_W-1:0]           cfg_wdata,
    output logic [ACC_W-1:0]           gain_level,
    output logic                       pwm_out,
    output logic                       gain_up,
    output logic                       gain_dn
);
    agc_cfg_t                   cfg_q;
    logic [REF_W-1:0]           ref_eff;
    logic signed [SAMPLE_W-1:0] samp;
    logic signed [SAMPLE_W:0]   dcr;
    logic                       hold_en;
    logic                       adv;

    // Input selection and sample acceptance
    always_comb begin
        samp    = in_sel ? samp_b : samp_a;
        hold_en = cfg_q.hold;
        adv     = in_valid && !hold_en;
    end

    agc_regs #(.DEFAULT_REF(DEFAULT_REF)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
        .wdata(cfg_wdata), .cfg_o(cfg_q), .ref_o(ref_eff)
    );

    agc_dc_reduce #(.SAMPLE_W(SAMPLE_W), .DC_SHIFT(DC_SHIFT)) u_dc (
        .clk(clk), .rst_n(rst_n), .adv(adv), .x_i(samp), .dcr_o(dcr)
    );

    agc_err_acc #(
        .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .REF_W(REF_W),
        .LO_THR(LO_THR), .HI_THR(HI_THR), .ACC_RST(ACC_RST)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .adv(adv), .hold(hold_en),
        .dcr_i(dcr), .ref_i(ref_eff), .acc_o(gain_level),
        .up_o(gain_up), .dn_o(gain_dn)
    );

    agc_pwm #(.PWM_W(PWM_W)) u_pwm (
        .clk(clk), .rst_n(rst_n), .run(!hold_en),
        .duty(gain_level[ACC_W-1 -: PWM_W]), .pwm_o(pwm_out)
    );
endmodule

// File: rtl/agc_loop_ctrl_chk.sv
// Checker for the AGC loop: timing properties of the gain word and the pulses.
module agc_loop_ctrl_chk #(
    parameter int               ACC_W   = 16,
    parameter logic [ACC_W-1:0] LO_THR  = 16'h2000,
    parameter logic [ACC_W-1:0] HI_THR  = 16'hE000,
    parameter logic [ACC_W-1:0] ACC_RST = 16'h8000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             hold_en,
    input logic [ACC_W-1:0] gain_level,
    input logic             gain_up,
    input logic             gain_dn
);
    // R1
    reset_value_chk: assert property (@(posedge clk)
        !rst_n |=> (gain_level == ACC_RST && !gain_up && !gain_dn));

    // R4
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(gain_level));

    // R7
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_en |=> ($stable(gain_level) && !gain_up && !gain_dn));

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gain_up && gain_dn));

    // R9
    up_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_up |-> (gain_level < LO_THR));

    // R9
    dn_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_dn |-> (gain_level > HI_THR));

    // R9
    up_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_up |=> !gain_up);

    // R9
    dn_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_dn |=> !gain_dn);
endmodule

bind agc_loop_ctrl agc_loop_ctrl_chk #(
    .ACC_W(ACC_W), .LO_THR(LO_THR), .HI_THR(HI_THR), .ACC_RST(ACC_RST)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hold_en(hold_en),
    .gain_level(gain_level), .gain_up(gain_up), .gain_dn(gain_dn)
);

// File: tb/agc_loop_ctrl_test.sv
`timescale 1ns/1ps
// Directed bench for the AGC loop. Each task drives one scenario and checks
// the results against a model built from the requirements.
module agc_loop_ctrl_test;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_sel = 1'b0;
    logic signed [9:0] samp_a = '0;
    logic signed [9:0] samp_b = '0;
    logic              in_valid = 1'b0;
    logic              cfg_wr = 1'b0;
    logic              cfg_addr = 1'b0;
    logic [7:0]        cfg_wdata = '0;
    logic [15:0]       gain_level;
    logic              pwm_out, gain_up, gain_dn;

    int errors = 0;
    int checks = 0;
    int up_seen = 0;
    int dn_seen = 0;
    int exp_up = 0;
    int exp_dn = 0;
    bit done = 1'b0;

    // Model state
    int  m_macc = 0;
    int  m_acc  = 32768;
    bit  m_hold = 1'b0;
    bit  m_sel  = 1'b0;
    int  m_refv = 0;

    always #2.5 clk = ~clk;

    agc_loop_ctrl uut (
        .clk(clk), .rst_n(rst_n), .in_sel(in_sel), .samp_a(samp_a),
        .samp_b(samp_b), .in_valid(in_valid), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .gain_level(gain_level),
        .pwm_out(pwm_out), .gain_up(gain_up), .gain_dn(gain_dn)
    );

    // Count gain pulses away from the active edge
    always @(negedge clk) begin
        if (gain_up) up_seen++;
        if (gain_dn) dn_seen++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic int ref_now();
        return m_sel ? m_refv : 64;
    endfunction

    // Model of one accepted sample
    task automatic model_step(input int x);
        int mean, d, mag, s;
        if (m_hold) return;
        mean = m_macc >>> 8;
        d    = x - mean;
        mag  = (d < 0) ? -d : d;
        s    = m_acc + mag - ref_now();
        if (s < 0) s = 0;
        if (s > 65535) s = 65535;
        if (s > 57344 && m_acc <= 57344) exp_dn++;
        if (s < 8192 && m_acc >= 8192) exp_up++;
        m_acc  = s;
        m_macc = m_macc + d;
    endtask

    task automatic send(input int a, input int b, input string req);
        @(negedge clk);
        samp_a = 10'(a); samp_b = 10'(b); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        model_step(in_sel ? b : a);
        chk(gain_level == 16'(m_acc), req, gain_level, m_acc);
    endtask

    task automatic wr_reg(input bit addr, input int data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = addr; cfg_wdata = 8'(data);
        @(negedge clk);
        cfg_wr = 1'b0;
        if (!addr) begin m_hold = data[0]; m_sel = data[1]; end
        else m_refv = data & 255;
    endtask

    task automatic pwm_check(input string req);
        int hi = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
        chk(hi == (m_acc >> 8), req, hi, m_acc >> 8);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(gain_level == 16'h8000, "R1 gain_level", gain_level, 32768);
        chk(!gain_up && !gain_dn, "R1 pulses", {gain_up, gain_dn}, 0);
        pwm_check("R1/R10 duty at reset");
    endtask

    task automatic t_dc_default();
        // First sample: mean 0, default ref 64 -> 32768 + 100 - 64
        send(100, 0, "R5 first sample");
        chk(gain_level == 16'h8024, "R5 default ref", gain_level, 32804);
        for (int i = 0; i < 40; i++) send(300, 0, "R3 constant offset");
    endtask

    task automatic t_input_sel();
        in_sel = 1'b1;
        for (int i = 0; i < 4; i++) send(0, -200, "R2 source B");
        in_sel = 1'b0;
        for (int i = 0; i < 4; i++) send(-150, 400, "R2 source A");
    endtask

    task automatic t_ref_select();
        wr_reg(1'b1, 200);
        send(250, 0, "R5 host value ignored with select 0");
        wr_reg(1'b0, 2);
        send(250, 0, "R6 host ref 200 in use");
        wr_reg(1'b1, 10);
        send(-250, 0, "R6 new ref on next sample");
        wr_reg(1'b0, 0);
        send(250, 0, "R5 back to default");
    endtask

    task automatic t_hold();
        int lvl;
        logic p;
        wr_reg(1'b0, 1);
        lvl = gain_level;
        p = pwm_out;
        for (int i = 0; i < 5; i++) send(500, -500, "R7 samples ignored");
        chk(gain_level == 16'(lvl), "R7 level frozen", gain_level, lvl);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pwm_out !== p) begin
                chk(1'b0, "R7 pwm frozen", pwm_out, p);
                break;
            end
        end
        chk(up_seen == exp_up && dn_seen == exp_dn, "R7 no pulses", up_seen + dn_seen, exp_up + exp_dn);
        wr_reg(1'b0, 0);
        for (int i = 0; i < 3; i++) send(120, 0, "R7 mean unchanged after release");
    endtask

    task automatic t_sat_high();
        int n = 0;
        while (m_acc < 65535 && n < 400) begin
            send((n % 2) ? -500 : 500, 0, "R8 rising");
            n++;
        end
        for (int i = 0; i < 5; i++) send(500, 0, "R8 upper clamp");
        chk(gain_level == 16'hFFFF, "R8 stays at 65535", gain_level, 65535);
        @(negedge clk);
        chk(dn_seen == exp_dn && exp_dn >= 1, "R9 gain_dn once", dn_seen, exp_dn);
        chk(up_seen == exp_up, "R9 no gain_up while rising", up_seen, exp_up);
        pwm_check("R10 full duty");
    endtask

    task automatic t_sat_low();
        int n = 0;
        while (m_acc > 0 && n < 3000) begin
            send(0, 0, "R8 falling");
            n++;
        end
        for (int i = 0; i < 5; i++) send(0, 0, "R8 lower clamp");
        chk(gain_level == 16'h0000, "R8 stays at 0", gain_level, 0);
        @(negedge clk);
        chk(up_seen == exp_up && exp_up >= 1, "R9 gain_up once", up_seen, exp_up);
        chk(dn_seen == exp_dn, "R9 no gain_dn while falling", dn_seen, exp_dn);
        pwm_check("R10 zero duty");
    endtask

    task automatic t_idle();
        int lvl = gain_level;
        repeat (10) @(negedge clk);
        chk(gain_level == 16'(lvl), "R4 no change without in_valid", gain_level, lvl);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dc_default();
        t_input_sel();
        t_ref_select();
        t_idle();
        t_hold();
        t_sat_high();
        t_sat_low();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule